// File: doc/BRIEF.md
# Branch History Record Stack

This block keeps a short circular history of control-flow transfers. Each entry holds the linear address an event left from, the linear address it went to, and a 2-bit kind code. The upstream pipeline offers records through a valid/ready port, and recording is filtered. Debug exceptions are never kept. A performance-monitor interrupt can freeze the history when freezing is armed. A mode input lets recording continue while only trace messages are enabled, because trace messages are built from the stored entries.

The stack has a power-of-two depth. A top-of-stack index names the newest entry. Each new entry goes to the next slot and replaces the oldest entry once the ring is full. A debugger reads any slot through a combinational index port.

Kind codes: 0 = taken branch, 1 = interrupt, 2 = exception, 3 = debug exception. The offer port never stalls, so `rec_ready` is always 1. A record is taken only in a cycle where both `rec_valid` and `rec_ready` are high. A record that the filter rejects is consumed and dropped.

Top module: `lbr_stack`

## Requirements
- R1: With `hist_en` high, an accepted record of kind 0, 1 or 2 is written on the clock edge into slot `tos+1` (modulo DEPTH), with its source, destination and kind.
- R2: A record of kind 3 (debug exception) is never written, and `tos` does not move for it.
- R3: Lowering `hist_en` stops new writes, and every stored entry stays readable without change.
- R4: When `pmi_req` and `freeze_arm` are both high, the record offered in that cycle is dropped and `frozen` reads 1 from the next cycle. No record is written while `frozen` is 1. A `pmi_req` while `freeze_arm` is low has no effect.
- R5: A `freeze_clr` pulse lowers `frozen` on the next cycle and leaves the entries unchanged. If `pmi_req` with `freeze_arm` arrives in the same cycle as `freeze_clr`, the freeze wins.
- R6: After reset `tos` is 0. `tos` advances by one on each write, modulo DEPTH, so the oldest entry is overwritten once the ring is full.
- R7: With `hist_en` low and `trace_en` high, records are written when `keep_on_trace` is 1 and dropped when `keep_on_trace` is 0.
- R8: `rd_src`, `rd_dst` and `rd_kind` show slot `rd_idx` combinationally, and reading never changes `tos`.
- R9: `rec_ready` is 1 at all times outside reset.
- R10: Reset clears every entry to zero and lowers `frozen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Stack can take a record (always 1) |
| rec_kind | input | 2 | Kind code of the offered record |
| rec_src | input | AW | Source linear address |
| rec_dst | input | AW | Destination linear address |
| hist_en | input | 1 | Branch-record enable |
| trace_en | input | 1 | Trace-message enable |
| keep_on_trace | input | 1 | Keep recording while only trace messages are enabled |
| freeze_arm | input | 1 | Freeze on performance-monitor interrupt |
| pmi_req | input | 1 | Performance-monitor interrupt strobe |
| freeze_clr | input | 1 | Software strobe that lifts the freeze |
| frozen | output | 1 | Stack is frozen |
| tos | output | IW | Index of the newest entry |
| rd_idx | input | IW | Debugger read index |
| rd_src | output | AW | Source address at `rd_idx` |
| rd_dst | output | AW | Destination address at `rd_idx` |
| rd_kind | output | 2 | Kind code at `rd_idx` |

## Verification
The assertions check on every cycle that the index steps by exactly one per write and holds otherwise, that no debug exception and no write while frozen gets through, that a freeze persists until it is cleared, and that nothing is written while both enable paths are closed. Only the bench scenarios can show that the right addresses land in the right slots: the contents after a wrap, the entries kept across a disable or a freeze release, and the agreement of the trace-only mode with a reference model under random traffic.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    K_BRANCH = 2'd0,
    K_INTR   = 2'd1,
    K_EXCEPT = 2'd2,
    K_DEBUG  = 2'd3
  } rec_kind_t;
endpackage

// File: rtl/lbr_freeze.sv
module lbr_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_arm,
  input  logic pmi_req,
  input  logic freeze_clr,
  output logic frozen,
  output logic block
);
  logic frz_q;
  logic trip;

  assign trip   = pmi_req & freeze_arm;
  assign block  = frz_q | trip;
  assign frozen = frz_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          frz_q <= 1'b0;
    else if (trip)       frz_q <= 1'b1;
    else if (freeze_clr) frz_q <= 1'b0;
  end

  AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !freeze_clr) |=> frz_q); // R5
  AST_FREEZE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pmi_req && freeze_arm) |=> frz_q); // R4
endmodule

// File: rtl/lbr_filter.sv
module lbr_filter
  import lbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_valid,
  input  logic       rec_ready,
  input  logic [1:0] rec_kind,
  input  logic       hist_en,
  input  logic       trace_en,
  input  logic       keep_on_trace,
  input  logic       block,
  output logic       accept
);
  logic path_open;
  logic kind_ok;

  assign path_open = hist_en | (trace_en & keep_on_trace);
  assign kind_ok   = (rec_kind != K_DEBUG);
  assign accept    = rec_valid & rec_ready & kind_ok & path_open & ~block;

  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hist_en && !(trace_en && keep_on_trace)) |-> !accept); // R7
endmodule

// File: rtl/lbr_ram.sv
module lbr_ram #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic [1:0]    wr_kind,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic [1:0]    rd_kind,
  output logic [IW-1:0] tos
);
  logic [AW-1:0] src_mem  [DEPTH];
  logic [AW-1:0] dst_mem  [DEPTH];
  logic [1:0]    kind_mem [DEPTH];
  logic [IW-1:0] tos_q;
  logic [IW-1:0] slot;

  assign slot = tos_q + IW'(1);
  assign tos  = tos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tos_q <= '0;
    else if (wr_en) tos_q <= slot;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_mem[g]  <= '0;
        dst_mem[g]  <= '0;
        kind_mem[g] <= '0;
      end else if (wr_en && slot == IW'(g)) begin
        src_mem[g]  <= wr_src;
        dst_mem[g]  <= wr_dst;
        kind_mem[g] <= wr_kind;
      end
    end
  end

  assign rd_src  = src_mem[rd_idx];
  assign rd_dst  = dst_mem[rd_idx];
  assign rd_kind = kind_mem[rd_idx];

  AST_TOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tos_q == ($past(tos_q) + IW'(1))); // R6
  AST_TOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tos_q)); // R8
endmodule

// File: rtl/lbr_stack.sv
module lbr_stack
  import lbr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [1:0]    rec_kind,
  input  logic [AW-1:0] rec_src,
  input  logic [AW-1:0] rec_dst,
  input  logic          hist_en,
  input  logic          trace_en,
  input  logic          keep_on_trace,
  input  logic          freeze_arm,
  input  logic          pmi_req,
  input  logic          freeze_clr,
  output logic          frozen,
  output logic [IW-1:0] tos,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic [1:0]    rd_kind
);
  logic block;
  logic wr_en;

  assign rec_ready = 1'b1;

  lbr_freeze u_freeze (
    .clk(clk), .rst_n(rst_n), .freeze_arm(freeze_arm), .pmi_req(pmi_req),
    .freeze_clr(freeze_clr), .frozen(frozen), .block(block)
  );

  lbr_filter u_filter (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_kind(rec_kind), .hist_en(hist_en), .trace_en(trace_en),
    .keep_on_trace(keep_on_trace), .block(block), .accept(wr_en)
  );

  lbr_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src(rec_src), .wr_dst(rec_dst),
    .wr_kind(rec_kind), .rd_idx(rd_idx), .rd_src(rd_src), .rd_dst(rd_dst),
    .rd_kind(rd_kind), .tos(tos)
  );

  AST_NO_DEBUG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind == K_DEBUG) |=> $stable(tos)); // R2
  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(tos)); // R4
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready); // R9
endmodule

// File: tb/sim_lbr_stack.sv
`timescale 1ns/1ps
module sim_lbr_stack;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int IW    = $clog2(DEPTH);

  logic clk = 0;
  logic rst_n = 0;
  logic rec_valid = 0, rec_ready;
  logic [1:0] rec_kind = 0;
  logic [AW-1:0] rec_src = 0, rec_dst = 0;
  logic hist_en = 0, trace_en = 0, keep_on_trace = 0, freeze_arm = 0;
  logic pmi_req = 0, freeze_clr = 0, frozen;
  logic [IW-1:0] tos, rd_idx = 0;
  logic [AW-1:0] rd_src, rd_dst;
  logic [1:0] rd_kind;

  int total = 0, bad = 0;
  logic [AW-1:0] m_src [DEPTH];
  logic [AW-1:0] m_dst [DEPTH];
  logic [1:0]    m_kind [DEPTH];
  logic [IW-1:0] m_tos = 0;
  logic          m_frz = 0;

  always #2.5 clk = ~clk;

  lbr_stack #(.DEPTH(DEPTH), .AW(AW)) u0 (.*);

  function automatic bit will_write(bit v, logic [1:0] k, bit pmi);
    return v && k != 2'd3 && (hist_en || (trace_en && keep_on_trace))
           && !m_frz && !(pmi && freeze_arm);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] k, logic [AW-1:0] s, logic [AW-1:0] d,
                      bit pmi, bit clr, string req);
    logic [IW-1:0] n;
    rec_valid = v; rec_kind = k; rec_src = s; rec_dst = d;
    pmi_req = pmi; freeze_clr = clr;
    if (will_write(v, k, pmi)) begin
      n = m_tos + IW'(1);
      m_src[n] = s; m_dst[n] = d; m_kind[n] = k; m_tos = n;
    end
    if (pmi && freeze_arm) m_frz = 1;
    else if (clr) m_frz = 0;
    @(posedge clk);
    @(negedge clk);
    rec_valid = 0; pmi_req = 0; freeze_clr = 0;
    chk(req, "tos", tos, m_tos);
    chk(req, "frozen", frozen, m_frz);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = IW'(i);
      #0.5;
      chk(req, "src", rd_src, m_src[i]);
      chk(req, "dst", rd_dst, m_dst[i]);
      chk(req, "kind", rd_kind, m_kind[i]);
    end
    chk("R8", "tos after read", tos, m_tos);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    for (int i = 0; i < DEPTH; i++) begin m_src[i] = 0; m_dst[i] = 0; m_kind[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R10", "tos reset", tos, 0);
    chk("R10", "frozen reset", frozen, 0);
    chk("R9", "ready", rec_ready, 1);
    check_all("R10");

    // R1: plain recording of each recordable kind
    hist_en = 1;
    step(1, 2'd0, 32'h1000, 32'h2000, 0, 0, "R1");
    step(1, 2'd1, 32'h1100, 32'h2100, 0, 0, "R1");
    step(1, 2'd2, 32'h1200, 32'h2200, 0, 0, "R1");
    check_all("R1");
    // R2: debug exception skipped
    step(1, 2'd3, 32'hDEAD, 32'hBEEF, 0, 0, "R2");
    check_all("R2");
    // R3: disable keeps entries
    hist_en = 0;
    step(1, 2'd0, 32'h3000, 32'h4000, 0, 0, "R3");
    check_all("R3");
    // R7: trace-only mode
    trace_en = 1; keep_on_trace = 0;
    step(1, 2'd0, 32'h5000, 32'h6000, 0, 0, "R7");
    keep_on_trace = 1;
    step(1, 2'd1, 32'h5100, 32'h6100, 0, 0, "R7");
    check_all("R7");
    trace_en = 0; keep_on_trace = 0; hist_en = 1;
    // R4: pmi without arm ignored, then armed freeze drops same-cycle record
    step(1, 2'd0, 32'h7000, 32'h7100, 1, 0, "R4");
    freeze_arm = 1;
    step(1, 2'd0, 32'h7200, 32'h7300, 1, 0, "R4");
    step(1, 2'd2, 32'h7400, 32'h7500, 0, 0, "R4");
    check_all("R4");
    // R5: clear and pmi together -> freeze holds; then clear alone
    step(0, 2'd0, 0, 0, 1, 1, "R5");
    step(0, 2'd0, 0, 0, 0, 1, "R5");
    check_all("R5");
    step(1, 2'd1, 32'h7600, 32'h7700, 0, 0, "R5");
    // R6: wrap around the ring
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, 2'(i % 3), 32'h8000 + i, 32'h9000 + i, 0, 0, "R6");
    check_all("R6");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 50 == 0) begin
        hist_en = $urandom() % 2; trace_en = $urandom() % 2;
        keep_on_trace = $urandom() % 2; freeze_arm = $urandom() % 2;
      end
      step($urandom() % 4 != 0, 2'($urandom()), $urandom(), $urandom(),
           $urandom() % 40 == 0, $urandom() % 6 == 0, "R1");
      if (n % 64 == 0) check_all("R8");
    end
    check_all("R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule